// File: doc/BRIEF.md
# Timed Configuration-Bit Readback Unit

This block sits beside a small processor's program-memory load path and lets firmware read its own fuse and lock settings. Firmware arms a special read mode by writing two bits of a control register: a self-program enable bit and a read-configuration bit. If a program-memory load arrives within a short window after that write, it returns configuration data instead of program code. The low two address bits of that load pick the lock bits, the low fuse byte or the high fuse byte.

The armed state expires by itself. A load that takes the configuration data ends it. So does a load window that closes with no load, a store window that closes with no store, or a store instruction. Configuration inputs carry a "programmed" flag per bit, and the unit returns them inverted: a programmed bit reads 0 and an unprogrammed bit reads 1. Every load result is registered and appears one cycle after its strobe, with a valid flag.

Top module: `cfg_readback_unit`

## Requirements
- R1: A control write with `ctl_wdata` = 2'b11 (bit 0 is the enable bit, bit 1 is the read-configuration bit) makes `ctl_bits` read 2'b11 on the next cycle. The read mode is armed only while both bits are set.
- R2: A load issued in cycle 1, 2 or 3 after the arming write cycle returns configuration data, and `ctl_bits` reads 2'b00 on the next cycle.
- R3: If no load comes in those three cycles, both bits clear at the end of the third cycle. A later load returns `pmem_rdata`.
- R4: With only the enable bit written (2'b01), loads return `pmem_rdata` and leave the bits unchanged. Both bits clear at the end of the fourth cycle after the write if no store arrives.
- R5: A store strobe while the enable bit is set clears both bits on the next cycle.
- R6: During an armed load, `ld_addr[1:0]` selects the data and higher address bits are ignored: 00 gives the fuse low byte, 01 gives the lock bits, 11 gives the fuse high byte, and 10 gives 8'hFF and still ends the armed state.
- R7: Configuration bits come back inverted: a programmed flag of 1 reads as 0.
- R8: A lock read places the two inverted lock bits in result bits 1:0 and ones in bits 7:2.
- R9: A control write with the enable bit clear leaves `ctl_bits` at 2'b00 on the next cycle, whatever the read-configuration bit is.
- R10: An arming write while already armed restarts the window, so that a load in the third cycle after the newer write still returns configuration data.
- R11: Each load strobe gives `ld_valid` = 1 and its result on the next cycle. Without a strobe, `ld_valid` is 0 and `ld_result` holds its value.
- R12: After reset, `ctl_bits`, `ld_valid` and `ld_result` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 2 | Control write data: bit 0 enable, bit 1 read-configuration |
| ctl_bits | output | 2 | Current control bits, same layout as the write data |
| ld_stb | input | 1 | Program-memory load strobe |
| ld_addr | input | 16 | Load address |
| pmem_rdata | input | 8 | Normal program-memory data for the load |
| ld_valid | output | 1 | Load result valid, one cycle after the strobe |
| ld_result | output | 8 | Registered load result |
| st_stb | input | 1 | Store instruction strobe |
| fuse_lo_prog | input | 8 | Programmed flags of the fuse low byte |
| fuse_hi_prog | input | 8 | Programmed flags of the fuse high byte |
| lock_prog | input | 2 | Programmed flags of the lock bits |

## Verification
Some behaviours are checked by assertions on every cycle. The read-configuration bit never stands without the enable bit. The cycle counter stays inside the load window while armed and inside the store window otherwise. An armed load or a store ends the mode on the next edge. Filler and lock reads have the required constant upper bits. A result holds while no load strobe is present. Other behaviours only the bench scenarios can show: the exact cycle on which each window closes, a restarted window after a second arming write, the address-to-source mapping with real fuse values, and the inversion of each configuration bit.

// File: rtl/cfg_rb_pkg.sv
package cfg_rb_pkg;
  localparam int CTL_W   = 2;
  localparam int EN_POS  = 0;
  localparam int RD_POS  = 1;
  localparam int SEL_W   = 2;

  typedef enum logic [SEL_W-1:0] {
    SEL_FUSE_LO = 2'b00,
    SEL_LOCK    = 2'b01,
    SEL_FILL    = 2'b10,
    SEL_FUSE_HI = 2'b11
  } cfg_sel_e;
endpackage

// File: rtl/cfg_rb_ctl.sv
module cfg_rb_ctl
  import cfg_rb_pkg::*;
#(
  parameter int LD_WIN = 3,
  parameter int ST_WIN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             ld_stb,
  input  logic             st_stb,
  output logic             armed,
  output logic [CTL_W-1:0] ctl_bits
);
  localparam int MAX_WIN = (ST_WIN > LD_WIN) ? ST_WIN : LD_WIN;
  localparam int CNT_W   = $clog2(MAX_WIN) + 1;

  logic             en_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             ld_expire, st_expire, consume;

  assign armed     = en_q & rd_q;
  assign ld_expire = armed && (cnt_q == CNT_W'(LD_WIN - 1));
  assign st_expire = cnt_q == CNT_W'(ST_WIN - 1);
  assign consume   = (armed && ld_stb) || st_stb;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      rd_q  <= 1'b0;
      cnt_q <= '0;
    end else if (ctl_we) begin
      en_q  <= ctl_wdata[EN_POS];
      rd_q  <= ctl_wdata[RD_POS] & ctl_wdata[EN_POS];
      cnt_q <= '0;
    end else if (en_q) begin
      if (consume || ld_expire || st_expire) begin
        en_q  <= 1'b0;
        rd_q  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    ctl_bits         = '0;
    ctl_bits[EN_POS] = en_q;
    ctl_bits[RD_POS] = rd_q;
  end

  // R9: read-configuration bit never set alone
  p_rd_needs_en_r9: assert property (@(posedge clk) disable iff (rst)
    rd_q |-> en_q);
  // R3: armed counter stays inside the load window
  p_ld_window_r3: assert property (@(posedge clk) disable iff (rst)
    armed |-> (cnt_q < CNT_W'(LD_WIN)));
  // R4: counter stays inside the store window
  p_st_window_r4: assert property (@(posedge clk) disable iff (rst)
    en_q |-> (cnt_q < CNT_W'(ST_WIN)));
  // R2: an armed load ends the mode
  p_consume_r2: assert property (@(posedge clk) disable iff (rst)
    (armed && ld_stb && !ctl_we) |=> (!en_q && !rd_q));
  // R5: a store ends the window
  p_store_r5: assert property (@(posedge clk) disable iff (rst)
    (en_q && st_stb && !ctl_we) |=> !en_q);
  // R1: arming write
  p_arm_r1: assert property (@(posedge clk) disable iff (rst)
    (ctl_we && ctl_wdata == 2'b11) |=> (armed && cnt_q == '0));
endmodule

// File: rtl/cfg_rb_mux.sv
module cfg_rb_mux
  import cfg_rb_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LOCK_W = 2
) (
  input  logic [SEL_W-1:0]  sel,
  input  logic [DATA_W-1:0] fuse_lo_prog,
  input  logic [DATA_W-1:0] fuse_hi_prog,
  input  logic [LOCK_W-1:0] lock_prog,
  output logic [DATA_W-1:0] cfg_byte
);
  logic [DATA_W-1:0] lock_byte;

  generate
    if (LOCK_W < DATA_W) begin : g_pad
      assign lock_byte = {{(DATA_W - LOCK_W){1'b1}}, ~lock_prog};
    end else begin : g_full
      assign lock_byte = ~lock_prog[DATA_W-1:0];
    end
  endgenerate

  always_comb begin
    unique case (cfg_sel_e'(sel))
      SEL_FUSE_LO: cfg_byte = ~fuse_lo_prog;
      SEL_LOCK:    cfg_byte = lock_byte;
      SEL_FUSE_HI: cfg_byte = ~fuse_hi_prog;
      default:     cfg_byte = '1;
    endcase
  end
endmodule

// File: rtl/cfg_rb_out.sv
module cfg_rb_out #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld_stb,
  input  logic              use_cfg,
  input  logic [DATA_W-1:0] cfg_byte,
  input  logic [DATA_W-1:0] pmem_rdata,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_result
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ld_valid  <= 1'b0;
      ld_result <= '0;
    end else begin
      ld_valid <= ld_stb;
      if (ld_stb) ld_result <= use_cfg ? cfg_byte : pmem_rdata;
    end
  end

  // R11: no strobe, no new result
  p_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !ld_stb |=> (!ld_valid && $stable(ld_result)));
  // R11: a strobe always produces a valid result
  p_valid_r11: assert property (@(posedge clk) disable iff (rst)
    ld_stb |=> ld_valid);
endmodule

// File: rtl/cfg_readback_unit.sv
module cfg_readback_unit
  import cfg_rb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int LOCK_W = 2,
  parameter int LD_WIN = 3,
  parameter int ST_WIN = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_bits,
  input  logic              ld_stb,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [DATA_W-1:0] pmem_rdata,
  output logic              ld_valid,
  output logic [DATA_W-1:0] ld_result,
  input  logic              st_stb,
  input  logic [DATA_W-1:0] fuse_lo_prog,
  input  logic [DATA_W-1:0] fuse_hi_prog,
  input  logic [LOCK_W-1:0] lock_prog
);
  logic              armed;
  logic [DATA_W-1:0] cfg_byte;
  logic              addr_hi_unused;

  assign addr_hi_unused = ^ld_addr[ADDR_W-1:SEL_W];

  cfg_rb_ctl #(.LD_WIN(LD_WIN), .ST_WIN(ST_WIN)) u_ctl (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ld_stb(ld_stb), .st_stb(st_stb), .armed(armed), .ctl_bits(ctl_bits)
  );

  cfg_rb_mux #(.DATA_W(DATA_W), .LOCK_W(LOCK_W)) u_mux (
    .sel(ld_addr[SEL_W-1:0]), .fuse_lo_prog(fuse_lo_prog),
    .fuse_hi_prog(fuse_hi_prog), .lock_prog(lock_prog), .cfg_byte(cfg_byte)
  );

  cfg_rb_out #(.DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst), .ld_stb(ld_stb), .use_cfg(armed),
    .cfg_byte(cfg_byte), .pmem_rdata(pmem_rdata),
    .ld_valid(ld_valid), .ld_result(ld_result)
  );

  // R6: filler address returns all ones when armed
  p_fill_r6: assert property (@(posedge clk) disable iff (rst)
    (armed && ld_stb && ld_addr[SEL_W-1:0] == 2'b10) |=> (ld_result == '1));
  // R8: lock read upper bits are ones
  p_lock_ones_r8: assert property (@(posedge clk) disable iff (rst)
    (armed && ld_stb && ld_addr[SEL_W-1:0] == 2'b01)
      |=> (ld_result[DATA_W-1:LOCK_W] == '1));
endmodule

// File: tb/test_cfg_readback_unit.sv
`timescale 1ns/100ps
module test_cfg_readback_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ctl_we = 1'b0;
  logic [1:0]  ctl_wdata = '0;
  logic [1:0]  ctl_bits;
  logic        ld_stb = 1'b0;
  logic [15:0] ld_addr = '0;
  logic [7:0]  pmem_rdata = '0;
  logic        ld_valid;
  logic [7:0]  ld_result;
  logic        st_stb = 1'b0;
  logic [7:0]  fuse_lo_prog = '0;
  logic [7:0]  fuse_hi_prog = '0;
  logic [1:0]  lock_prog = '0;

  int vectors = 0;
  int errors  = 0;

  // bench model state
  logic       m_en = 0, m_rd = 0, m_valid = 0;
  logic [7:0] m_res = 0;
  int         m_cnt = 0;

  always #2.5 clk = ~clk;

  cfg_readback_unit i_cfg_readback_unit (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_bits(ctl_bits), .ld_stb(ld_stb), .ld_addr(ld_addr),
    .pmem_rdata(pmem_rdata), .ld_valid(ld_valid), .ld_result(ld_result),
    .st_stb(st_stb), .fuse_lo_prog(fuse_lo_prog),
    .fuse_hi_prog(fuse_hi_prog), .lock_prog(lock_prog)
  );

  function automatic logic [7:0] cfg_expect(input logic [1:0] a);
    case (a)
      2'b00:   return ~fuse_lo_prog;
      2'b01:   return {6'h3F, ~lock_prog};
      2'b11:   return ~fuse_hi_prog;
      default: return 8'hFF;
    endcase
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // advance one cycle with current inputs, update model, compare
  task automatic tick(input string tag);
    logic armed;
    armed = m_en & m_rd;
    if (ld_stb) begin
      m_valid = 1;
      m_res = armed ? cfg_expect(ld_addr[1:0]) : pmem_rdata;
    end else m_valid = 0;
    if (ctl_we) begin
      m_en = ctl_wdata[0]; m_rd = ctl_wdata[1] & ctl_wdata[0]; m_cnt = 0;
    end else if (m_en) begin
      if ((armed && ld_stb) || st_stb || (armed && m_cnt == 2) || m_cnt == 3) begin
        m_en = 0; m_rd = 0; m_cnt = 0;
      end else m_cnt++;
    end
    @(posedge clk);
    @(negedge clk);
    check(tag, "ctl_bits", {6'd0, ctl_bits}, {6'd0, m_rd, m_en});
    check(tag, "ld_valid", {7'd0, ld_valid}, {7'd0, m_valid});
    check(tag, "ld_result", ld_result, m_res);
    ctl_we = 0; ld_stb = 0; st_stb = 0;
  endtask

  task automatic wr(input logic [1:0] d, input string tag);
    ctl_we = 1; ctl_wdata = d; tick(tag);
  endtask
  task automatic ld(input logic [15:0] a, input string tag);
    ld_stb = 1; ld_addr = a; pmem_rdata = 8'($urandom); tick(tag);
  endtask
  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(tag);
  endtask

  initial begin
    #(5.0 * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    // R12 reset state
    check("R12", "ctl_bits", {6'd0, ctl_bits}, 8'd0);
    check("R12", "ld_valid", {7'd0, ld_valid}, 8'd0);
    check("R12", "ld_result", ld_result, 8'd0);

    fuse_lo_prog = 8'hA5; fuse_hi_prog = 8'h3C; lock_prog = 2'b10;
    wr(2'b11, "R1");
    idle(2, "R2");
    ld(16'h0000, "R2");              // third cycle: still in window
    ld(16'h0000, "R7");              // mode consumed: normal data
    wr(2'b11, "R3");
    idle(3, "R3");
    ld(16'h0001, "R3");              // window closed
    wr(2'b11, "R8"); ld(16'h0001, "R8");
    lock_prog = 2'b01;
    wr(2'b11, "R7"); ld(16'h0001, "R7");
    wr(2'b11, "R6"); ld(16'h0003, "R6");
    wr(2'b11, "R6"); ld(16'h0002, "R6");
    ld(16'h0000, "R6");              // filler consumed the mode
    wr(2'b11, "R6"); ld(16'h8001, "R6");
    wr(2'b01, "R4"); ld(16'h0000, "R4"); idle(3, "R4"); idle(1, "R4");
    wr(2'b01, "R5"); tick("R5"); st_stb = 1; tick("R5");
    wr(2'b11, "R5"); st_stb = 1; tick("R5"); ld(16'h0000, "R5");
    wr(2'b11, "R9"); wr(2'b10, "R9"); ld(16'h0000, "R9");
    wr(2'b11, "R10"); idle(2, "R10"); wr(2'b11, "R10"); idle(2, "R10");
    ld(16'h0003, "R10");
    ld(16'h0001, "R11"); idle(2, "R11");

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      if (r < 8) begin
        fuse_lo_prog = 8'($urandom); fuse_hi_prog = 8'($urandom);
        lock_prog = 2'($urandom);
      end
      ctl_we = ($urandom_range(0, 99) < 15);
      ctl_wdata = ($urandom_range(0, 99) < 60) ? 2'b11 : 2'($urandom);
      ld_stb = ($urandom_range(0, 99) < 30);
      ld_addr = 16'($urandom);
      pmem_rdata = 8'($urandom);
      st_stb = ($urandom_range(0, 99) < 5);
      tick((m_en & m_rd) ? "R2" : "R4");
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule